// File: doc/BRIEF.md
# Slot EVM Measurement Engine

This engine measures error vector magnitude over one time slot. It receives two complex sample streams in lockstep: the measured signal and the ideal reference for the same instant. Over one slot it accumulates the power of the error vector (measured minus reference) and the power of the reference. When the slot closes it divides the two sums and takes the square root. The result is an unsigned fixed-point number. It is either a plain ratio or that ratio multiplied by one hundred, so that it reads as a percent.

An optional correction step removes the mean I and Q offset of the measured samples before the error is formed. Neither the samples nor a second pass over the slot is needed for this. The engine keeps the per-lane sums of the measured values and of the error, and applies the closed-form expansion of the corrected error power once the slot ends. The divide and the square root run bit-serially. A single-cycle done strobe marks the result, and the result and the error flag hold until the next strobe.

Top module: `evm_engine`

## Requirements
- R1: With the percent select low, evm_o equals floor(sqrt(floor(E * 2^16 / P))), a value with 8 fractional bits. E is the sum over the slot of (dI^2 + dQ^2) with d = measured - reference per lane. P is the sum of (refI^2 + refQ^2).
- R2: With the percent select high, the dividend is also multiplied by 10000, so evm_o equals floor(sqrt(floor(E * 10000 * 2^16 / P))). This is 100 times the ratio, with 8 fractional bits.
- R3: A window opens on a valid sample that has slot_start high. It closes on the SLOT_LEN-th valid sample. Cycles with s_valid low are not counted, so gaps are allowed inside a window.
- R4: A valid sample with slot_start high, arriving inside an open window, discards the partial sums and opens a new window with that sample as its first.
- R5: Valid samples are ignored when no window is open: idle without slot_start, or while a result is being computed. This holds even when slot_start is high during the computation.
- R6: With correction enabled, the mean of the measured samples over the slot is subtracted per lane before the error is formed. E becomes the sum of |m - mean(m) - r|^2, computed exactly with no rounding of the mean.
- R7: The percent select and the correction enable are sampled with the slot_start sample. Changes later in the window have no effect on that window.
- R8: If P is zero, evm_o is 0xFFFF and evm_ref_err_o is 1 at done.
- R9: If the quotient does not fit in 32 bits, evm_o saturates at 0xFFFF and evm_ref_err_o is 0.
- R10: evm_done_o is a one-cycle pulse. evm_o and evm_ref_err_o change only in that cycle and hold until the next pulse.
- R11: After reset, evm_o is 0, evm_done_o is 0 and evm_ref_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample pair valid |
| s_slot_start | input | 1 | First sample of a measurement window |
| s_meas_i | input | DW | Measured in-phase sample, signed |
| s_meas_q | input | DW | Measured quadrature sample, signed |
| s_ref_i | input | DW | Reference in-phase sample, signed |
| s_ref_q | input | DW | Reference quadrature sample, signed |
| cfg_pct | input | 1 | 1: report percent, 0: report ratio |
| cfg_corr | input | 1 | 1: remove measured IQ origin offset |
| evm_o | output | OW | EVM result, FRAC fractional bits |
| evm_done_o | output | 1 | Result strobe |
| evm_ref_err_o | output | 1 | Reference power was zero |

## Verification
The minimum-spacing property assumes that at most one sample arrives per clock. It also assumes that reset is not pulsed between done strobes, because the property counts cycles rather than samples. The hold properties assume that nothing but a finished computation writes the result. The stimulus keeps every sample component within the signed 12-bit range, so the sums cannot wrap. It raises slot_start freely, including mid-window and during computation, and feeds idle gaps inside windows.

// File: rtl/evm_pkg.sv
`timescale 1ns/1ps
package evm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACC, ST_LOAD, ST_DIV, ST_SQRT, ST_FIN
  } evm_state_e;

  localparam int PCT_SCALE   = 10000;
  localparam int PCT_SCALE_W = 14;
endpackage

// File: rtl/evm_accum.sv
`timescale 1ns/1ps
module evm_accum #(
  parameter int DW   = 12,
  parameter int CNTW = 12,
  parameter int ACCW = 2*DW + 2 + CNTW,
  parameter int SMW  = DW + CNTW,
  parameter int SDW  = DW + 1 + CNTW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   clr,
  input  logic signed [DW-1:0]   m_i,
  input  logic signed [DW-1:0]   m_q,
  input  logic signed [DW-1:0]   r_i,
  input  logic signed [DW-1:0]   r_q,
  output logic [ACCW-1:0]        esq_o,
  output logic [ACCW-1:0]        rsq_o,
  output logic signed [SMW-1:0]  sm_i_o,
  output logic signed [SMW-1:0]  sm_q_o,
  output logic signed [SDW-1:0]  sd_i_o,
  output logic signed [SDW-1:0]  sd_q_o
);
  logic signed [DW-1:0]  mv [2];
  logic signed [DW-1:0]  rv [2];
  logic [2*DW+1:0]       dsq [2];
  logic [2*DW-1:0]       rsq [2];
  logic signed [SMW-1:0] sm_arr [2];
  logic signed [SDW-1:0] sd_arr [2];
  logic [ACCW-1:0]       esq_q, rsq_q;

  assign mv[0] = m_i;
  assign mv[1] = m_q;
  assign rv[0] = r_i;
  assign rv[1] = r_q;

  for (genvar c = 0; c < 2; c++) begin : g_lane
    logic signed [DW:0]      d;
    logic signed [2*DW+1:0]  dp;
    logic signed [2*DW-1:0]  rp;
    logic signed [SMW-1:0]   sm_r;
    logic signed [SDW-1:0]   sd_r;

    assign d  = $signed({mv[c][DW-1], mv[c]}) - $signed({rv[c][DW-1], rv[c]});
    assign dp = d * d;
    assign rp = rv[c] * rv[c];
    assign dsq[c] = $unsigned(dp);
    assign rsq[c] = $unsigned(rp);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sm_r <= '0;
        sd_r <= '0;
      end else if (en) begin
        sm_r <= (clr ? '0 : sm_r) + SMW'(mv[c]);
        sd_r <= (clr ? '0 : sd_r) + SDW'(d);
      end
    end

    assign sm_arr[c] = sm_r;
    assign sd_arr[c] = sd_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esq_q <= '0;
      rsq_q <= '0;
    end else if (en) begin
      esq_q <= (clr ? '0 : esq_q) + ACCW'(dsq[0]) + ACCW'(dsq[1]);
      rsq_q <= (clr ? '0 : rsq_q) + ACCW'(rsq[0]) + ACCW'(rsq[1]);
    end
  end

  assign esq_o  = esq_q;
  assign rsq_o  = rsq_q;
  assign sm_i_o = sm_arr[0];
  assign sm_q_o = sm_arr[1];
  assign sd_i_o = sd_arr[0];
  assign sd_q_o = sd_arr[1];
endmodule

// File: rtl/evm_divider.sv
`timescale 1ns/1ps
module evm_divider #(
  parameter int DVSW = 40,
  parameter int QW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVSW-1:0]  dvd_hi,
  input  logic [QW-1:0]    dvd_lo,
  input  logic [DVSW-1:0]  divisor,
  output logic             done,
  output logic [QW-1:0]    quot
);
  localparam int CW = $clog2(QW + 1);

  logic [DVSW-1:0] rem_q, rem_n, diff;
  logic [QW-1:0]   lo_q, quot_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, done_q, ge;
  logic [DVSW:0]   t;

  always_comb begin
    t     = {rem_q, lo_q[QW-1]};
    ge    = t >= {1'b0, divisor};
    diff  = t[DVSW-1:0] - divisor;
    rem_n = ge ? diff : t[DVSW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      lo_q   <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && (cnt_q == CW'(1));
      if (start) begin
        rem_q  <= dvd_hi;
        lo_q   <= dvd_lo;
        quot_q <= '0;
        cnt_q  <= CW'(QW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= rem_n;
        lo_q   <= lo_q << 1;
        quot_q <= {quot_q[QW-2:0], ge};
        cnt_q  <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign done = done_q;
  assign quot = quot_q;
endmodule

// File: rtl/evm_isqrt.sv
`timescale 1ns/1ps
module evm_isqrt #(
  parameter int OW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2*OW-1:0]   radicand,
  output logic              done,
  output logic [OW-1:0]     root
);
  localparam int IW = 2*OW;
  localparam int CW = $clog2(OW + 1);

  logic [IW-1:0]  xr_q;
  logic [OW+1:0]  rem_q, rem_n, diff;
  logic [OW-1:0]  root_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q, done_q, ge;
  logic [OW+3:0]  t, trial;

  always_comb begin
    t     = {rem_q, xr_q[IW-1 -: 2]};
    trial = {2'b00, root_q, 2'b01};
    ge    = t >= trial;
    diff  = t[OW+1:0] - trial[OW+1:0];
    rem_n = ge ? diff : t[OW+1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr_q   <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && (cnt_q == CW'(1));
      if (start) begin
        xr_q   <= radicand;
        rem_q  <= '0;
        root_q <= '0;
        cnt_q  <= CW'(OW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        xr_q   <= xr_q << 2;
        rem_q  <= rem_n;
        root_q <= {root_q[OW-2:0], ge};
        cnt_q  <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign done = done_q;
  assign root = root_q;
endmodule

// File: rtl/evm_engine.sv
`timescale 1ns/1ps
module evm_engine
  import evm_pkg::*;
#(
  parameter int DW       = 12,
  parameter int SLOT_LEN = 2560,
  parameter int OW       = 16,
  parameter int FRAC     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  input  logic                 s_slot_start,
  input  logic signed [DW-1:0] s_meas_i,
  input  logic signed [DW-1:0] s_meas_q,
  input  logic signed [DW-1:0] s_ref_i,
  input  logic signed [DW-1:0] s_ref_q,
  input  logic                 cfg_pct,
  input  logic                 cfg_corr,
  output logic [OW-1:0]        evm_o,
  output logic                 evm_done_o,
  output logic                 evm_ref_err_o
);
  localparam int CNTW   = $clog2(SLOT_LEN + 1);
  localparam int ACCW   = 2*DW + 2 + CNTW;
  localparam int SMW    = DW + CNTW;
  localparam int SDW    = DW + 1 + CNTW;
  localparam int DVSW   = ACCW + CNTW;
  localparam int ESW    = 2*DW + 2*CNTW + 6;
  localparam int QW     = 2*OW;
  localparam int NW_RAW = ESW + PCT_SCALE_W + 2*FRAC;
  localparam int NW     = (NW_RAW > QW + DVSW) ? NW_RAW : QW + DVSW;
  localparam logic signed [ESW-1:0] NLEN_S = ESW'(SLOT_LEN);
  localparam logic [DVSW-1:0]       NLEN_U = DVSW'(SLOT_LEN);

  evm_state_e state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d, cnt_nx;
  logic pct_q, pct_d, corr_q, corr_d, err_q, err_d;
  logic [OW-1:0] res_q, res_d;
  logic accept, restart, div_start, sq_start, div_done, sq_done, ovf;

  logic [ACCW-1:0] esq, rsq;
  logic signed [SMW-1:0] sm_i, sm_q;
  logic signed [SDW-1:0] sd_i, sd_q;
  logic signed [ESW-1:0] e_corr;
  logic [ESW-1:0]  e_val;
  logic [DVSW-1:0] r_val;
  logic [NW-1:0]   dvd;
  logic [QW-1:0]   quot;
  logic [OW-1:0]   root;

  // Window acceptance: open on slot_start from idle, any sample while accumulating.
  assign accept  = s_valid && ((state_q == ST_IDLE && s_slot_start) || state_q == ST_ACC);
  assign restart = accept && s_slot_start;
  assign cnt_nx  = restart ? CNTW'(1) : cnt_q + CNTW'(1);

  evm_accum #(.DW(DW), .CNTW(CNTW)) i_accum (
    .clk(clk), .rst_n(rst_n), .en(accept), .clr(restart),
    .m_i(s_meas_i), .m_q(s_meas_q), .r_i(s_ref_i), .r_q(s_ref_q),
    .esq_o(esq), .rsq_o(rsq), .sm_i_o(sm_i), .sm_q_o(sm_q),
    .sd_i_o(sd_i), .sd_q_o(sd_q)
  );

  // Closed-form offset removal: N*sum|d - Sm/N|^2 = N*Sd2 - 2*Sm*Sd + Sm^2 per lane.
  always_comb begin
    e_corr = NLEN_S * $signed({{(ESW-ACCW){1'b0}}, esq})
           + ESW'(sm_i) * ESW'(sm_i) - ((ESW'(sm_i) * ESW'(sd_i)) <<< 1)
           + ESW'(sm_q) * ESW'(sm_q) - ((ESW'(sm_q) * ESW'(sd_q)) <<< 1);
    e_val  = corr_q ? $unsigned(e_corr) : ESW'(esq);
    r_val  = corr_q ? NLEN_U * DVSW'(rsq) : DVSW'(rsq);
    dvd    = (NW'(e_val) * (pct_q ? NW'(PCT_SCALE) : NW'(1))) << (2*FRAC);
    ovf    = dvd >= (NW'(r_val) << QW);
  end

  evm_divider #(.DVSW(DVSW), .QW(QW)) i_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dvd_hi(dvd[QW +: DVSW]), .dvd_lo(dvd[QW-1:0]), .divisor(r_val),
    .done(div_done), .quot(quot)
  );

  evm_isqrt #(.OW(OW)) i_sqrt (
    .clk(clk), .rst_n(rst_n), .start(sq_start), .radicand(quot),
    .done(sq_done), .root(root)
  );

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    pct_d     = pct_q;
    corr_d    = corr_q;
    res_d     = res_q;
    err_d     = err_q;
    div_start = 1'b0;
    sq_start  = 1'b0;
    case (state_q)
      ST_IDLE, ST_ACC: begin
        if (accept) begin
          cnt_d = cnt_nx;
          if (restart) begin
            pct_d  = cfg_pct;
            corr_d = cfg_corr;
          end
          state_d = (cnt_nx == CNTW'(SLOT_LEN)) ? ST_LOAD : ST_ACC;
        end
      end
      ST_LOAD: begin
        if (r_val == '0) begin
          res_d = '1;  err_d = 1'b1;  state_d = ST_FIN;
        end else if (ovf) begin
          res_d = '1;  err_d = 1'b0;  state_d = ST_FIN;
        end else begin
          div_start = 1'b1;  state_d = ST_DIV;
        end
      end
      ST_DIV: if (div_done) begin
        sq_start = 1'b1;  state_d = ST_SQRT;
      end
      ST_SQRT: if (sq_done) begin
        res_d = root;  err_d = 1'b0;  state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pct_q   <= 1'b0;
      corr_q  <= 1'b0;
      res_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pct_q   <= pct_d;
      corr_q  <= corr_d;
      res_q   <= res_d;
      err_q   <= err_d;
    end
  end

  assign evm_o         = res_q;
  assign evm_ref_err_o = err_q;
  assign evm_done_o    = (state_q == ST_FIN);
endmodule

// File: rtl/evm_engine_chk.sv
`timescale 1ns/1ps
module evm_engine_chk #(
  parameter int SLOT_LEN = 2560,
  parameter int OW       = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evm_done_o,
  input logic          evm_ref_err_o,
  input logic [OW-1:0] evm_o
);
  localparam int GW = $clog2(SLOT_LEN + 1);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= '0;
    else if (evm_done_o)            gap_q <= '0;
    else if (gap_q != GW'(SLOT_LEN)) gap_q <= gap_q + GW'(1);
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    evm_done_o |=> !evm_done_o);

  a_r10_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evm_o) |-> evm_done_o);

  a_r10_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evm_ref_err_o) |-> evm_done_o);

  a_r8_err_max_code: assert property (@(posedge clk) disable iff (!rst_n)
    (evm_done_o && evm_ref_err_o) |-> (evm_o == {OW{1'b1}}));

  a_r3_min_window: assert property (@(posedge clk) disable iff (!rst_n)
    evm_done_o |-> (gap_q == GW'(SLOT_LEN)));
endmodule

bind evm_engine evm_engine_chk #(.SLOT_LEN(SLOT_LEN), .OW(OW)) i_chk (
  .clk(clk), .rst_n(rst_n), .evm_done_o(evm_done_o),
  .evm_ref_err_o(evm_ref_err_o), .evm_o(evm_o)
);

// File: tb/test_evm_engine.sv
`timescale 1ns/1ps
module test_evm_engine;
  localparam int N  = 16;
  localparam int DW = 12;

  typedef struct packed {
    logic               pct;
    logic               corr;
    logic               gap;
    logic [11:0]        ra;
    logic [11:0]        ea;
    logic signed [11:0] oi;
    logic signed [11:0] oq;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 1'b0, 12'd200,  12'd10,  12'sd0,   12'sd0},
    '{1'b1, 1'b0, 1'b0, 12'd200,  12'd10,  12'sd0,   12'sd0},
    '{1'b1, 1'b0, 1'b0, 12'd100,  12'd0,   12'sd0,   12'sd0},
    '{1'b1, 1'b1, 1'b0, 12'd200,  12'd10,  12'sd50,  -12'sd30},
    '{1'b1, 1'b0, 1'b0, 12'd200,  12'd10,  12'sd50,  -12'sd30},
    '{1'b0, 1'b1, 1'b1, 12'd150,  12'd20,  -12'sd40, 12'sd25},
    '{1'b1, 1'b0, 1'b1, 12'd1000, 12'd300, 12'sd0,   12'sd0},
    '{1'b0, 1'b0, 1'b0, 12'd1,    12'd400, 12'sd0,   12'sd0},
    '{1'b0, 1'b0, 1'b0, 12'd0,    12'd50,  12'sd0,   12'sd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic s_valid, s_slot_start, cfg_pct, cfg_corr;
  logic signed [DW-1:0] s_meas_i, s_meas_q, s_ref_i, s_ref_q;
  logic [15:0] evm_o;
  logic evm_done_o, evm_ref_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int bmi [N], bmq [N], bri [N], brq [N];
  logic [15:0] exp_evm;
  logic        exp_err;

  always #5 clk = ~clk;

  evm_engine #(.DW(DW), .SLOT_LEN(N)) i_evm_engine (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_slot_start(s_slot_start),
    .s_meas_i(s_meas_i), .s_meas_q(s_meas_q), .s_ref_i(s_ref_i), .s_ref_q(s_ref_q),
    .cfg_pct(cfg_pct), .cfg_corr(cfg_corr),
    .evm_o(evm_o), .evm_done_o(evm_done_o), .evm_ref_err_o(evm_ref_err_o)
  );

  always @(negedge clk) if (rst_n === 1'b1 && evm_done_o === 1'b1) done_cnt++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string vtag(input int v);
    case (v)
      0: return "R1";
      1, 2, 4: return "R2";
      3, 5: return "R6";
      6: return "R3";
      7: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic fill(input int v);
    for (int k = 0; k < N; k++) begin
      bri[k] = (k & 1) ? -int'(VECS[v].ra) : int'(VECS[v].ra);
      brq[k] = (k & 2) ? -int'(VECS[v].ra) : int'(VECS[v].ra);
      bmi[k] = bri[k] + (((k*3) % 5) - 2) * int'(VECS[v].ea) + int'(VECS[v].oi);
      bmq[k] = brq[k] + (((k*7) % 3) - 1) * int'(VECS[v].ea) + int'(VECS[v].oq);
    end
  endtask

  // Expected value straight from the requirement formulas (corrected form scaled by N^2).
  task automatic expect_of(input bit pct, input bit corr);
    longint smi = 0, smq = 0;
    bit [127:0] num = 0, den = 0, q;
    longint r = 0;
    for (int k = 0; k < N; k++) begin
      smi += bmi[k];
      smq += bmq[k];
    end
    for (int k = 0; k < N; k++) begin
      longint di = bmi[k] - bri[k];
      longint dq = bmq[k] - brq[k];
      longint ci = N*di - smi;
      longint cq = N*dq - smq;
      num += corr ? 128'(ci*ci + cq*cq) : 128'(di*di + dq*dq);
      den += 128'(longint'(bri[k])*bri[k] + longint'(brq[k])*brq[k]);
    end
    if (corr) den = den * N * N;
    if (den == 0) begin
      exp_evm = 16'hFFFF; exp_err = 1'b1;
    end else begin
      q = (num * (pct ? 10000 : 1) * 65536) / den;
      exp_err = 1'b0;
      if (q >= 128'h1_0000_0000) exp_evm = 16'hFFFF;
      else begin
        for (int b = 15; b >= 0; b--) begin
          longint cand = r | (longint'(1) << b);
          if (128'(cand*cand) <= q) r = cand;
        end
        exp_evm = 16'(r);
      end
    end
  endtask

  task automatic send(input int mi, input int mq, input int ri, input int rq, input bit sos);
    s_valid = 1'b1; s_slot_start = sos;
    s_meas_i = DW'(mi); s_meas_q = DW'(mq); s_ref_i = DW'(ri); s_ref_q = DW'(rq);
    @(negedge clk);
    s_valid = 1'b0; s_slot_start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    int t = 0;
    while (evm_done_o !== 1'b1 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    seen = (evm_done_o === 1'b1);
  endtask

  // flip: invert mode inputs after the first sample (R7). junk: slot-start traffic while computing (R5).
  task automatic run_vec(input int v, input bit flip, input bit junk, input string tag);
    bit seen;
    fill(v);
    expect_of(VECS[v].pct, VECS[v].corr);
    for (int k = 0; k < N; k++) begin
      if (k == 0) begin cfg_pct = VECS[v].pct; cfg_corr = VECS[v].corr; end
      if (flip && k == 1) begin cfg_pct = ~cfg_pct; cfg_corr = ~cfg_corr; end
      send(bmi[k], bmq[k], bri[k], brq[k], k == 0);
      if (VECS[v].gap && (k % 3 == 2)) @(negedge clk);
    end
    if (junk) for (int j = 0; j < 10; j++) send(900, -900, 3, 3, 1'b1);
    wait_done(seen);
    check(seen, {tag, " done"}, seen, 1);
    check(evm_o == exp_evm, {tag, " evm"}, evm_o, exp_evm);
    check(evm_ref_err_o == exp_err, {tag, " ref_err"}, evm_ref_err_o, exp_err);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; s_valid = 1'b0; s_slot_start = 1'b0; cfg_pct = 1'b0; cfg_corr = 1'b0;
    s_meas_i = '0; s_meas_q = '0; s_ref_i = '0; s_ref_q = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(evm_o == 0 && evm_done_o == 0 && evm_ref_err_o == 0, "R11 reset",
          {evm_o, evm_done_o, evm_ref_err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 9; v++) run_vec(v, 1'b0, 1'b0, vtag(v));

    // R10: done lasts one cycle, value and flag hold
    run_vec(0, 1'b0, 1'b0, "R10 base");
    check(evm_done_o == 0, "R10 pulse", evm_done_o, 0);
    repeat (20) @(negedge clk);
    check(evm_o == exp_evm && evm_ref_err_o == exp_err, "R10 hold", evm_o, exp_evm);

    // R4: partial window discarded by a new slot start
    base = done_cnt;
    fill(6);
    cfg_pct = 1'b1; cfg_corr = 1'b0;
    for (int k = 0; k < 7; k++) send(bmi[k], bmq[k], bri[k], brq[k], k == 0);
    run_vec(0, 1'b0, 1'b0, "R4 restart");
    check(done_cnt - base == 1, "R4 single done", done_cnt - base, 1);

    // R5: valid samples without slot start while idle are ignored
    base = done_cnt;
    for (int j = 0; j < 3*N; j++) send(500, 500, 7, 7, 1'b0);
    repeat (150) @(negedge clk);
    check(done_cnt == base, "R5 idle", done_cnt - base, 0);
    check(evm_o == exp_evm, "R5 idle value", evm_o, exp_evm);

    // R5: slot-start traffic during computation is ignored
    base = done_cnt;
    run_vec(1, 1'b0, 1'b1, "R5 busy");
    repeat (150) @(negedge clk);
    check(done_cnt - base == 1, "R5 busy no window", done_cnt - base, 1);

    // R7: mode inputs changed after the first sample have no effect
    run_vec(3, 1'b1, 1'b0, "R7 pct corr");
    run_vec(5, 1'b1, 1'b0, "R7 ratio corr");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule